// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This block wraps a small single-ported word store. It lets several requesting agents run indivisible operations on shared words. Each agent has its own request lane with a valid/ready handshake. A round-robin arbiter accepts one request at a time. A sequencer then reads the addressed word in one cycle and writes the new value back in the next. While that sequence runs, no other lane is granted, so no agent can reach the word between the read and the write.

The supported operations are plain load, plain store, test-and-set, swap, fetch-and-add and compare-and-swap. Every operation returns the word's previous contents to the agent that issued it. The return comes as a one-cycle done pulse on that agent's lane, together with a shared data bus and a success flag. Software builds locks on top of these operations. A lock is taken with test-and-set or compare-and-swap and released with a plain store of the free value.

Top module: `amo_unit`

## Requirements
- R1: While `rst` is high, every `req_ready` bit and every `rsp_done` bit is 0. Once reset has been applied, every word of the store reads 0.
- R2: At most one `req_ready` bit is high, and only on a lane whose `req_valid` is high. Grants rotate round-robin: after lane i is served, lanes i+1, i+2, ... (wrapping) are preferred over i. After reset, lane 0 has the highest priority.
- R3: A request is accepted in the cycle where its `req_valid` and `req_ready` are both high. For the next two cycles no lane is ready. The response appears in the third cycle after acceptance.
- R4: Op code 0 (load) returns the word and leaves it unchanged.
- R5: Op code 1 (store) writes `req_operand` to the word and returns the old contents.
- R6: Op code 2 (test-and-set) returns the old contents and writes parameter `SET_VAL` (default 1). `rsp_success` is 1 exactly when the old value equals parameter `FREE_VAL` (default 0).
- R7: Op code 3 (swap) writes `req_operand` and returns the prior contents.
- R8: Op code 4 (fetch-and-add) returns the old value and writes old + `req_operand` modulo 2^DATA_W. Concurrent increments from all lanes are never lost.
- R9: Op code 5 (compare-and-swap) writes `req_operand` only when the old value equals `req_compare`. `rsp_success` reports whether that write happened.
- R10: Op codes 6 and 7 behave as a load and never modify the store.
- R11: `rsp_done` is a one-cycle pulse on the issuing lane only. `rsp_old` carries the word's previous value. `rsp_success` is 1 for load, store, swap and fetch-and-add.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_PORTS | Per-lane request valid |
| req_ready | output | NUM_PORTS | Per-lane acceptance (grant) |
| req_op | input | 3*NUM_PORTS | Per-lane op code, lane k at bits [3k+2:3k] |
| req_addr | input | ADDR_W*NUM_PORTS | Per-lane word address |
| req_operand | input | DATA_W*NUM_PORTS | Store/swap value, addend, or compare-and-swap new value |
| req_compare | input | DATA_W*NUM_PORTS | Compare value for compare-and-swap |
| rsp_done | output | NUM_PORTS | One-cycle completion pulse on the issuing lane |
| rsp_old | output | DATA_W | Previous contents of the addressed word |
| rsp_success | output | 1 | Test-and-set acquire / compare-and-swap hit flag |

## Verification
The assertions check the handshake and locking properties on every cycle. These are the single grant, the grant only on a requesting lane, the two-cycle silence after each acceptance, the fixed response latency to the correct lane, the single-cycle done pulse, and round-robin rotation under contention. Whether each operation computes the right value, writes or spares the word, and sets the success flag correctly can only be shown by the bench's scenarios. The same holds for the contention cases: only one test-and-set acquirer wins, and no concurrent increment is lost. The bench follows these with its reference store.

// File: rtl/amo_pkg.sv
package amo_pkg;

    localparam logic [2:0] OP_LOAD  = 3'd0;
    localparam logic [2:0] OP_STORE = 3'd1;
    localparam logic [2:0] OP_TAS   = 3'd2;
    localparam logic [2:0] OP_SWAP  = 3'd3;
    localparam logic [2:0] OP_FADD  = 3'd4;
    localparam logic [2:0] OP_CAS   = 3'd5;

    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_READ  = 2'd1,
        SEQ_WRITE = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic writes;       // op produces a write-back
        logic from_operand; // new value is the requester operand
        logic from_set;     // new value is the lock-taken constant
        logic from_sum;     // new value is old + operand
        logic conditional;  // write only if old equals compare value
        logic lock_test;    // success means old equalled the free constant
    } op_ctl_t;

    function automatic op_ctl_t decode_op(logic [2:0] op);
        op_ctl_t c;
        c = '0;
        case (op)
            OP_STORE: begin c.writes = 1'b1; c.from_operand = 1'b1; end
            OP_TAS:   begin c.writes = 1'b1; c.from_set = 1'b1; c.lock_test = 1'b1; end
            OP_SWAP:  begin c.writes = 1'b1; c.from_operand = 1'b1; end
            OP_FADD:  begin c.writes = 1'b1; c.from_sum = 1'b1; end
            OP_CAS:   begin c.writes = 1'b1; c.from_operand = 1'b1; c.conditional = 1'b1; end
            default:  c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/amo_rr_arbiter.sv
module amo_rr_arbiter #(
    parameter int NP = 4,
    localparam int IW = (NP > 1) ? $clog2(NP) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [NP-1:0] req,
    input  logic          advance,
    output logic [NP-1:0] grant,
    output logic [IW-1:0] grant_idx
);

    logic [IW-1:0] last_q;

    always_comb begin
        logic found;
        int   idx;
        grant     = '0;
        grant_idx = '0;
        found     = 1'b0;
        for (int k = 1; k <= NP; k++) begin
            idx = (int'(last_q) + k) % NP;
            if (!found && req[idx]) begin
                grant[idx] = 1'b1;
                grant_idx  = IW'(idx);
                found      = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q <= IW'(NP - 1);
        end else if (advance) begin
            last_q <= grant_idx;
        end
    end

endmodule

// File: rtl/amo_word_store.sv
module amo_word_store #(
    parameter int DW = 32,
    parameter int AW = 4,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words_q[i] <= '0;
            end
            rdata <= '0;
        end else begin
            if (rd_en) begin
                rdata <= words_q[addr];
            end
            if (wr_en) begin
                words_q[addr] <= wdata;
            end
        end
    end

endmodule

// File: rtl/amo_exec.sv
module amo_exec
    import amo_pkg::*;
#(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] SET_VAL  = DW'(1),
    parameter logic [DW-1:0] FREE_VAL = '0
) (
    input  logic [2:0]    op,
    input  logic [DW-1:0] old_val,
    input  logic [DW-1:0] operand,
    input  logic [DW-1:0] compare,
    output logic [DW-1:0] new_val,
    output logic          wr_en,
    output logic          success
);

    op_ctl_t ctl;
    logic    cmp_hit;

    always_comb begin
        ctl     = decode_op(op);
        cmp_hit = (old_val == compare);
        if (ctl.from_set) begin
            new_val = SET_VAL;
        end else if (ctl.from_sum) begin
            new_val = old_val + operand;
        end else if (ctl.from_operand) begin
            new_val = operand;
        end else begin
            new_val = old_val;
        end
        wr_en = ctl.writes && (!ctl.conditional || cmp_hit);
        if (ctl.conditional) begin
            success = cmp_hit;
        end else if (ctl.lock_test) begin
            success = (old_val == FREE_VAL);
        end else begin
            success = 1'b1;
        end
    end

endmodule

// File: rtl/amo_unit.sv
module amo_unit
    import amo_pkg::*;
#(
    parameter int                NUM_PORTS = 4,
    parameter int                DATA_W    = 32,
    parameter int                ADDR_W    = 4,
    parameter logic [DATA_W-1:0] SET_VAL   = DATA_W'(1),
    parameter logic [DATA_W-1:0] FREE_VAL  = '0,
    localparam int               PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PORTS-1:0]          req_valid,
    output logic [NUM_PORTS-1:0]          req_ready,
    input  logic [3*NUM_PORTS-1:0]        req_op,
    input  logic [ADDR_W*NUM_PORTS-1:0]   req_addr,
    input  logic [DATA_W*NUM_PORTS-1:0]   req_operand,
    input  logic [DATA_W*NUM_PORTS-1:0]   req_compare,
    output logic [NUM_PORTS-1:0]          rsp_done,
    output logic [DATA_W-1:0]             rsp_old,
    output logic                          rsp_success
);

    typedef struct packed {
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] operand;
        logic [DATA_W-1:0] compare;
    } txn_t;

    txn_t       lane_txn [NUM_PORTS];
    txn_t       sel_txn;
    txn_t       txn_q;
    logic [PW-1:0] port_q;
    seq_state_e state_q;

    logic [NUM_PORTS-1:0] grant;
    logic [PW-1:0]        grant_idx;
    logic                 accept;

    logic [DATA_W-1:0] mem_rdata;
    logic [DATA_W-1:0] new_val;
    logic              exec_wr;
    logic              exec_ok;

    genvar g;
    generate
        for (g = 0; g < NUM_PORTS; g++) begin : g_lane
            assign lane_txn[g].op      = req_op[g*3 +: 3];
            assign lane_txn[g].addr    = req_addr[g*ADDR_W +: ADDR_W];
            assign lane_txn[g].operand = req_operand[g*DATA_W +: DATA_W];
            assign lane_txn[g].compare = req_compare[g*DATA_W +: DATA_W];
        end
    endgenerate

    amo_rr_arbiter #(.NP(NUM_PORTS)) arb_i (
        .clk       (clk),
        .rst       (rst),
        .req       (req_valid),
        .advance   (accept),
        .grant     (grant),
        .grant_idx (grant_idx)
    );

    assign req_ready = (!rst && state_q == SEQ_IDLE) ? grant : '0;
    assign accept    = |req_ready;

    always_comb begin
        sel_txn = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            if (grant[p]) begin
                sel_txn = sel_txn | lane_txn[p];
            end
        end
    end

    amo_word_store #(.DW(DATA_W), .AW(ADDR_W)) store_i (
        .clk   (clk),
        .rst   (rst),
        .addr  (txn_q.addr),
        .rd_en (state_q == SEQ_READ),
        .wr_en (state_q == SEQ_WRITE && exec_wr),
        .wdata (new_val),
        .rdata (mem_rdata)
    );

    amo_exec #(.DW(DATA_W), .SET_VAL(SET_VAL), .FREE_VAL(FREE_VAL)) exec_i (
        .op      (txn_q.op),
        .old_val (mem_rdata),
        .operand (txn_q.operand),
        .compare (txn_q.compare),
        .new_val (new_val),
        .wr_en   (exec_wr),
        .success (exec_ok)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SEQ_IDLE;
            txn_q       <= '0;
            port_q      <= '0;
            rsp_done    <= '0;
            rsp_old     <= '0;
            rsp_success <= 1'b0;
        end else begin
            rsp_done <= '0;
            case (state_q)
                SEQ_IDLE: begin
                    if (accept) begin
                        txn_q   <= sel_txn;
                        port_q  <= grant_idx;
                        state_q <= SEQ_READ;
                    end
                end
                SEQ_READ: begin
                    state_q <= SEQ_WRITE;
                end
                SEQ_WRITE: begin
                    rsp_done    <= NUM_PORTS'(1) << port_q;
                    rsp_old     <= mem_rdata;
                    rsp_success <= exec_ok;
                    state_q     <= SEQ_IDLE;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
    parameter int NP = 4
) (
    input logic          clk,
    input logic          rst,
    input logic [NP-1:0] req_valid,
    input logic [NP-1:0] req_ready,
    input logic [NP-1:0] rsp_done
);

    logic [NP-1:0] acc;
    assign acc = req_valid & req_ready;

    // R1
    rst_ready_low_chk: assert property (@(posedge clk) rst |-> (req_ready == '0));

    // R1
    rst_done_low_chk: assert property (@(posedge clk) rst |=> (rsp_done == '0));

    // R2
    single_grant_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(req_ready));

    // R2
    grant_on_request_chk: assert property (@(posedge clk) disable iff (rst)
        ((req_ready & ~req_valid) == '0));

    // R2
    rotate_chk: assert property (@(posedge clk) disable iff (rst)
        ((|acc) && ((acc & $past(acc, 3)) != '0)) |-> ((req_valid & ~acc) == '0));

    // R3
    lock_window_chk: assert property (@(posedge clk) disable iff (rst)
        (|acc) |=> (req_ready == '0) ##1 (req_ready == '0));

    // R3
    rsp_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (|acc) |=> ##2 (rsp_done == $past(acc, 3)));

    // R11
    done_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_done));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (|rsp_done) |=> (rsp_done == '0));

endmodule

bind amo_unit amo_unit_chk #(.NP(NUM_PORTS)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done)
);

// File: tb/amo_unit_tb_top.sv
module amo_unit_tb_top;
    import amo_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 4;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int MAXP = 64;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NP-1:0]       req_valid = '0;
    logic [NP-1:0]       req_ready;
    logic [3*NP-1:0]     req_op = '0;
    logic [AW*NP-1:0]    req_addr = '0;
    logic [DW*NP-1:0]    req_operand = '0;
    logic [DW*NP-1:0]    req_compare = '0;
    logic [NP-1:0]       rsp_done;
    logic [DW-1:0]       rsp_old;
    logic                rsp_success;

    always #(CLK_PERIOD/2) clk = ~clk;

    amo_unit #(.NUM_PORTS(NP), .DATA_W(DW), .ADDR_W(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_op      (req_op),
        .req_addr    (req_addr),
        .req_operand (req_operand),
        .req_compare (req_compare),
        .rsp_done    (rsp_done),
        .rsp_old     (rsp_old),
        .rsp_success (rsp_success)
    );

    typedef struct {
        logic [2:0]    op;
        logic [AW-1:0] addr;
        logic [DW-1:0] opnd;
        logic [DW-1:0] cmpv;
        string         tag;
    } item_t;

    typedef struct {
        bit            v;
        logic [NP-1:0] vec;
        logic [DW-1:0] old;
        bit            ok;
        string         tag;
    } ent_t;

    item_t         prog [NP][MAXP];
    int            cnt [NP];
    int            idx [NP];
    logic [DW-1:0] mmem [1 << AW];
    ent_t          d1, d2, d3;
    int            busy;
    int            last;
    int            checks = 0;
    int            errs = 0;
    bit            finished = 0;
    logic [DW-1:0] last_old;

    task automatic chk(bit ok, string tag, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic ent_t empty_ent();
        ent_t e;
        e.v = 0; e.vec = '0; e.old = '0; e.ok = 0; e.tag = "";
        return e;
    endfunction

    task automatic add(int p, logic [2:0] op, int a, logic [DW-1:0] opnd, logic [DW-1:0] cmpv, string tag);
        prog[p][cnt[p]].op   = op;
        prog[p][cnt[p]].addr = AW'(a);
        prog[p][cnt[p]].opnd = opnd;
        prog[p][cnt[p]].cmpv = cmpv;
        prog[p][cnt[p]].tag  = tag;
        cnt[p]++;
    endtask

    task automatic drive_all();
        for (int p = 0; p < NP; p++) begin
            if (idx[p] < cnt[p]) begin
                req_valid[p]              = 1'b1;
                req_op[p*3 +: 3]          = prog[p][idx[p]].op;
                req_addr[p*AW +: AW]      = prog[p][idx[p]].addr;
                req_operand[p*DW +: DW]   = prog[p][idx[p]].opnd;
                req_compare[p*DW +: DW]   = prog[p][idx[p]].cmpv;
            end else begin
                req_valid[p] = 1'b0;
            end
        end
    endtask

    function automatic logic [NP-1:0] pick(logic [NP-1:0] v);
        for (int k = 1; k <= NP; k++) begin
            int i;
            i = (last + k) % NP;
            if (v[i]) return NP'(1) << i;
        end
        return '0;
    endfunction

    task automatic step();
        logic [NP-1:0] exp_rdy;
        logic [NP-1:0] acc;
        @(negedge clk);
        exp_rdy = (busy == 0) ? pick(req_valid) : '0;
        chk(req_ready == exp_rdy, "R2/R3", "req_ready", DW'(req_ready), DW'(exp_rdy));
        chk(rsp_done == d3.vec, "R11", "rsp_done", DW'(rsp_done), DW'(d3.vec));
        if (d3.v) begin
            chk(rsp_old == d3.old, d3.tag, "rsp_old", rsp_old, d3.old);
            chk(rsp_success == d3.ok, d3.tag, "rsp_success", DW'(rsp_success), DW'(d3.ok));
        end
        if (|rsp_done) last_old = rsp_old;
        acc = req_valid & req_ready;
        d3 = d2; d2 = d1; d1 = empty_ent();
        if (|acc) begin
            int p;
            item_t it;
            logic [DW-1:0] old;
            p = 0;
            for (int i = 0; i < NP; i++) if (acc[i]) p = i;
            it  = prog[p][idx[p]];
            old = mmem[it.addr];
            d1.v = 1; d1.vec = NP'(1) << p; d1.old = old; d1.ok = 1; d1.tag = it.tag;
            case (it.op)
                OP_STORE, OP_SWAP: mmem[it.addr] = it.opnd;
                OP_FADD: mmem[it.addr] = old + it.opnd;
                OP_TAS: begin mmem[it.addr] = DW'(1); d1.ok = (old == '0); end
                OP_CAS: begin
                    d1.ok = (old == it.cmpv);
                    if (d1.ok) mmem[it.addr] = it.opnd;
                end
                default: ;
            endcase
            last = p;
            busy = 2;
        end else if (busy > 0) begin
            busy--;
        end
        @(posedge clk);
        #1;
        for (int i = 0; i < NP; i++) if (acc[i]) idx[i]++;
        drive_all();
    endtask

    function automatic bit pending();
        for (int p = 0; p < NP; p++) if (idx[p] < cnt[p]) return 1;
        return (busy > 0) || d1.v || d2.v || d3.v;
    endfunction

    task automatic run_program();
        drive_all();
        step();
        while (pending()) step();
        step();
    endtask

    task automatic clear_prog();
        for (int p = 0; p < NP; p++) begin cnt[p] = 0; idx[p] = 0; end
    endtask

    initial begin
        for (int i = 0; i < (1 << AW); i++) mmem[i] = '0;
        d1 = empty_ent(); d2 = empty_ent(); d3 = empty_ent();
        busy = 0; last = NP - 1; last_old = '0;
        clear_prog();

        // Phase 1: single lane, every op code and lock handling
        add(0, OP_LOAD, 3, 0, 0, "R1");
        add(0, OP_STORE, 3, 32'h55, 0, "R5");
        add(0, OP_LOAD, 3, 0, 0, "R4");
        add(0, 3'd6, 3, 32'h99, 32'h55, "R10");
        add(0, 3'd7, 3, 32'h77, 0, "R10");
        add(0, OP_LOAD, 3, 0, 0, "R10");
        add(0, OP_TAS, 5, 0, 0, "R6");
        add(0, OP_TAS, 5, 0, 0, "R6");
        add(0, OP_STORE, 5, 0, 0, "R6");
        add(0, OP_TAS, 5, 0, 0, "R6");
        add(0, OP_SWAP, 3, 32'hAA, 0, "R7");
        add(0, OP_LOAD, 3, 0, 0, "R7");
        add(0, OP_STORE, 7, 5, 0, "R5");
        add(0, OP_FADD, 7, 32'hFFFF_FFFF, 0, "R8");
        add(0, OP_LOAD, 7, 0, 0, "R8");
        add(0, OP_STORE, 7, 32'hFFFF_FFFF, 0, "R8");
        add(0, OP_FADD, 7, 2, 0, "R8");
        add(0, OP_LOAD, 7, 0, 0, "R8");
        add(0, OP_CAS, 9, 7, 0, "R9");
        add(0, OP_CAS, 9, 8, 0, "R9");
        add(0, OP_LOAD, 9, 0, 0, "R9");

        // Reset: lane 0 requests but must not be granted
        drive_all();
        repeat (3) begin
            @(negedge clk);
            chk(req_ready == '0, "R1", "req_ready in reset", DW'(req_ready), '0);
            chk(rsp_done == '0, "R1", "rsp_done in reset", DW'(rsp_done), '0);
        end
        @(posedge clk);
        #1 rst = 1'b0;

        run_program();

        // Phase 2: another lane alone, response to the right lane
        clear_prog();
        add(3, OP_CAS, 9, 9, 7, "R9");
        add(3, OP_LOAD, 9, 0, 0, "R11");
        run_program();

        // Phase 3: all lanes contend: increments, lock race, compare-and-swap race
        clear_prog();
        for (int p = 0; p < NP; p++) begin
            for (int k = 0; k < 10; k++) begin
                add(p, OP_FADD, 12, 1, 0, "R8");
                if (k == 3) add(p, OP_TAS, 14, 0, 0, "R6");
                if (k == 6) add(p, OP_CAS, 10, DW'(p + 1), 0, "R9");
                if (k == 8) add(p, OP_SWAP, 2, DW'(p + 20), 0, "R7");
            end
        end
        run_program();

        // Phase 4: read back the shared counter
        clear_prog();
        add(1, OP_LOAD, 12, 0, 0, "R8");
        run_program();
        chk(last_old == DW'(NP * 10), "R8", "final counter", last_old, DW'(NP * 10));

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errs++;
            checks++;
            $display("FAIL R3 watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

endmodule